// File: doc/BRIEF.md
# Dual-Bank Numerically Controlled Waveform Oscillator

This block is a single-clock numerically controlled oscillator. A 28-bit phase accumulator advances every clock by one of two stored tuning words, and one of two stored 12-bit phase offsets is added to the accumulator's top 12 bits. The resulting phase is turned into a 10-bit unsigned sample. The sample is either a sine, taken from a table folded over a quarter wave, or a linear up/down triangle ramp. A 1-bit square output follows the phase MSB.

Software programs the tuning words, phase offsets and a control word through a simple parallel write port. Bank selection can follow two external select pins, or two control bits. A synchronous clear input zeroes the accumulator and pipeline and parks the sample at midscale, while every programmed register keeps its value. A sleep pin, or a sleep control bit, forces the sample to zero. A frequency or phase hop is done by loading the idle bank and then flipping the select, so the switch happens on a known clock.

Top module: `nco_dual_bank`

## Requirements
- R1: On every clock without clear, the accumulator adds the selected 28-bit tuning word modulo 2^28. The phase sum is the accumulator's top 12 bits plus the selected 12-bit offset, modulo 2^12.
- R2: The frequency bank is control bit 0 when control bit 2 is 1, and `fbank_pin` when control bit 2 is 0. The pin is sampled at the rising edge where the accumulator updates.
- R3: The phase bank is control bit 1 when control bit 2 is 1, and `pbank_pin` when control bit 2 is 0. The pin is sampled at the rising edge where the phase sum register updates.
- R4: When control bit 3 is 0, the sample comes from the sine path. Let a be the top 10 phase-sum bits and h = a[8:0]. The sample is within 2 LSB of 512 + 511·sin(π(2h+1)/1024) when a[9]=0, and within 2 LSB of 511 − 511·sin(π(2h+1)/1024) when a[9]=1.
- R5: When control bit 3 is 1, the sample is phase-sum bits [10:1] when the phase-sum MSB is 0, and the bitwise inverse of those bits when the MSB is 1.
- R6: While `clear` is high, the accumulator and phase sum are zeroed at each edge and the sample reads 512 after that edge. The tuning, offset and control registers keep their values, and writes made during clear are accepted. Clear takes priority over sleep.
- R7: When `sleep_pin` or control bit 4 is 1 at an edge (without clear), the sample reads 0 after that edge. The accumulator keeps running and the square output is unaffected.
- R8: `square_o` equals control bit 5 AND the phase-sum MSB, registered in the same stage as the sample.
- R9: A write with `wr_en`=1 stores `wr_data` at that edge. Address 0 is tuning word 0, address 1 is tuning word 1, address 2 is offset 0, address 3 is offset 1 (low 12 bits), and address 4 is the control word (low 6 bits). Addresses 5 to 7 are ignored. A new tuning word first moves the accumulator one edge later, and it reaches the sample three edges after the write.
- R10: While `rst_n` is low, all registers are zero, `sample_o` is 512 and `square_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 28 | Write data |
| fbank_pin | input | 1 | External frequency bank select |
| pbank_pin | input | 1 | External phase bank select |
| clear | input | 1 | Synchronous datapath clear, active high |
| sleep_pin | input | 1 | Sample power-down, active high |
| sample_o | output | 10 | Unsigned waveform sample |
| square_o | output | 1 | Square output from phase MSB |

## Verification
A pin or tuning change seen at edge k moves the accumulator at k. It reaches the phase sum at k+1 and the sample at k+2. An offset-bank pin change at k shows in the sample at k+1. Sleep, clear and the output-stage control bits act at the very next edge, and a register write reaches the sample three edges later. The bench keeps a cycle model that is updated on the same rising edge as the design. Inputs change only on falling edges, and every output is compared on the falling edge after each rising edge, so each result is checked in the exact cycle it is due. Full phase sweeps in both waveform modes cover every sine and triangle address.

// File: rtl/nco_pkg.sv
package nco_pkg;
   localparam int unsigned ADDR_W = 3;
   localparam logic [ADDR_W-1:0] A_FTW0  = 3'd0;
   localparam logic [ADDR_W-1:0] A_FTW1  = 3'd1;
   localparam logic [ADDR_W-1:0] A_POFF0 = 3'd2;
   localparam logic [ADDR_W-1:0] A_POFF1 = 3'd3;
   localparam logic [ADDR_W-1:0] A_CTRL  = 3'd4;

   typedef struct packed {
      logic sq_en;     // bit 5
      logic sleep;     // bit 4
      logic tri_mode;  // bit 3
      logic sel_src;   // bit 2: 1 = control bits, 0 = pins
      logic pbank;     // bit 1
      logic fbank;     // bit 0
   } nco_ctrl_t;

   localparam int unsigned CTRL_W = $bits(nco_ctrl_t);

   // Rational half-wave sine approximation, amplitude 2^(outw-1)-1, sampled at bin centres
   function automatic longint sine_mag(longint h, int outw);
      longint d, n, p, amp;
      d   = longint'(1) << outw;
      n   = 2 * h + 1;
      p   = n * (d - n);
      amp = (longint'(1) << (outw - 1)) - 1;
      return (amp * 16 * p) / (5 * d * d - 4 * p);
   endfunction
endpackage

// File: rtl/nco_regbank.sv
module nco_regbank
   import nco_pkg::*;
#(
   parameter int unsigned ACC_W = 28,
   parameter int unsigned PH_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [ACC_W-1:0]  wr_data,
   input  logic              fbank_pin,
   input  logic              pbank_pin,
   output logic [ACC_W-1:0]  ftw_sel,
   output logic [PH_W-1:0]   poff_sel,
   output nco_ctrl_t         ctrl
);
   localparam int unsigned NBANK = 2;

   logic [ACC_W-1:0] ftw_q  [NBANK];
   logic [PH_W-1:0]  poff_q [NBANK];
   nco_ctrl_t        ctrl_q;

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ftw_q[b]  <= '0;
            poff_q[b] <= '0;
         end else if (wr_en) begin
            if (wr_addr == A_FTW0 + ADDR_W'(b))  ftw_q[b]  <= wr_data;
            if (wr_addr == A_POFF0 + ADDR_W'(b)) poff_q[b] <= wr_data[PH_W-1:0];
         end
      end

      p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !wr_en |=> ($stable(ftw_q[b]) && $stable(poff_q[b])));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             ctrl_q <= '0;
      else if (wr_en && wr_addr == A_CTRL)    ctrl_q <= nco_ctrl_t'(wr_data[CTRL_W-1:0]);
   end

   logic fsel, psel;
   always_comb begin
      fsel     = ctrl_q.sel_src ? ctrl_q.fbank : fbank_pin;
      psel     = ctrl_q.sel_src ? ctrl_q.pbank : pbank_pin;
      ftw_sel  = ftw_q[fsel];
      poff_sel = poff_q[psel];
      ctrl     = ctrl_q;
   end

   p_ctrl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == A_CTRL) |=> $stable(ctrl_q));
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
   parameter int unsigned ACC_W = 28,
   parameter int unsigned PH_W  = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [ACC_W-1:0] ftw,
   input  logic [PH_W-1:0]  poff,
   output logic [PH_W-1:0]  phase
);
   logic [ACC_W-1:0] acc_q;
   logic [PH_W-1:0]  ps_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         ps_q  <= '0;
      end else if (clear) begin
         acc_q <= '0;
         ps_q  <= '0;
      end else begin
         acc_q <= acc_q + ftw;
         ps_q  <= acc_q[ACC_W-1 -: PH_W] + poff;
      end
   end

   assign phase = ps_q;

   p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (acc_q == '0 && ps_q == '0));
endmodule

// File: rtl/nco_wave_shaper.sv
module nco_wave_shaper
   import nco_pkg::*;
#(
   parameter int unsigned PH_W      = 12,
   parameter int unsigned OUT_W     = 10,
   parameter bit          SINE_FOLD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             sleep,
   input  logic             tri_mode,
   input  logic             sq_en,
   input  logic [PH_W-1:0]  phase,
   output logic [OUT_W-1:0] sample,
   output logic             square
);
   localparam int unsigned MAG_W = OUT_W - 1;
   localparam int unsigned QDEPTH = 1 << (OUT_W - 2);
   localparam int unsigned FDEPTH = 1 << OUT_W;
   localparam logic [OUT_W-1:0] MID = OUT_W'(1) << (OUT_W - 1);

   logic [OUT_W-1:0] addr;
   logic [OUT_W-1:0] sine_code;
   logic [OUT_W-1:0] tri_code;
   logic [OUT_W-1:0] tri_raw;

   assign addr    = phase[PH_W-1 -: OUT_W];
   assign tri_raw = phase[PH_W-2 -: OUT_W];
   assign tri_code = phase[PH_W-1] ? ~tri_raw : tri_raw;

   if (SINE_FOLD) begin : g_quarter
      logic [MAG_W-1:0] rom [QDEPTH];
      logic [OUT_W-3:0] qidx;
      logic [MAG_W-1:0] mag;
      for (genvar i = 0; i < QDEPTH; i++) begin : g_rom
         localparam logic [MAG_W-1:0] V = MAG_W'(sine_mag(longint'(i), OUT_W));
         assign rom[i] = V;
      end
      assign qidx = addr[OUT_W-2] ? ~addr[OUT_W-3:0] : addr[OUT_W-3:0];
      assign mag  = rom[qidx];
      assign sine_code = addr[OUT_W-1] ? (MID - OUT_W'(1) - {1'b0, mag})
                                       : (MID + {1'b0, mag});
   end else begin : g_full
      logic [OUT_W-1:0] rom [FDEPTH];
      for (genvar i = 0; i < FDEPTH; i++) begin : g_rom
         localparam longint M = sine_mag(longint'(i % (FDEPTH / 2)), OUT_W);
         localparam logic [OUT_W-1:0] V = (i >= FDEPTH / 2) ?
            OUT_W'(longint'(MID) - 1 - M) : OUT_W'(longint'(MID) + M);
         assign rom[i] = V;
      end
      assign sine_code = rom[addr];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sample <= MID;
         square <= 1'b0;
      end else if (clear) begin
         sample <= MID;
         square <= 1'b0;
      end else begin
         sample <= sleep ? '0 : (tri_mode ? tri_code : sine_code);
         square <= sq_en & phase[PH_W-1];
      end
   end

   p_sleep_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep && !clear) |=> (sample == '0));
   p_midscale_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (sample == MID && !square));
   p_square_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !sq_en |=> !square);
endmodule

// File: rtl/nco_dual_bank.sv
module nco_dual_bank
   import nco_pkg::*;
#(
   parameter int unsigned ACC_W     = 28,
   parameter int unsigned PH_W      = 12,
   parameter int unsigned OUT_W     = 10,
   parameter bit          SINE_FOLD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [ACC_W-1:0]  wr_data,
   input  logic              fbank_pin,
   input  logic              pbank_pin,
   input  logic              clear,
   input  logic              sleep_pin,
   output logic [OUT_W-1:0]  sample_o,
   output logic              square_o
);
   if (OUT_W < 4) begin : g_bad_out
      $error("nco_dual_bank: OUT_W must be at least 4");
   end
   if (PH_W < OUT_W + 1) begin : g_bad_ph
      $error("nco_dual_bank: PH_W must exceed OUT_W");
   end
   if (ACC_W < PH_W) begin : g_bad_acc
      $error("nco_dual_bank: ACC_W must be at least PH_W");
   end
   if (ACC_W < CTRL_W) begin : g_bad_ctrl
      $error("nco_dual_bank: ACC_W too narrow for control word");
   end

   logic [ACC_W-1:0] ftw_sel;
   logic [PH_W-1:0]  poff_sel;
   logic [PH_W-1:0]  phase;
   nco_ctrl_t        ctrl;

   nco_regbank #(.ACC_W(ACC_W), .PH_W(PH_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .fbank_pin(fbank_pin), .pbank_pin(pbank_pin),
      .ftw_sel(ftw_sel), .poff_sel(poff_sel), .ctrl(ctrl)
   );

   nco_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clear(clear),
      .ftw(ftw_sel), .poff(poff_sel), .phase(phase)
   );

   nco_wave_shaper #(.PH_W(PH_W), .OUT_W(OUT_W), .SINE_FOLD(SINE_FOLD)) u_shape (
      .clk(clk), .rst_n(rst_n), .clear(clear),
      .sleep(sleep_pin | ctrl.sleep), .tri_mode(ctrl.tri_mode), .sq_en(ctrl.sq_en),
      .phase(phase), .sample(sample_o), .square(square_o)
   );

   p_reset_mid_r10: assert property (@(posedge clk)
      $rose(rst_n) |-> (sample_o == (OUT_W'(1) << (OUT_W - 1)) && !square_o));
endmodule

// File: tb/nco_dual_bank_tb.sv
module nco_dual_bank_tb;
   localparam time CLK_PERIOD = 10ns;
   localparam int  WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [27:0] wr_data = '0;
   logic        fbank_pin = 1'b0, pbank_pin = 1'b0;
   logic        clear = 1'b0, sleep_pin = 1'b0;
   logic [9:0]  sample_o;
   logic        square_o;

   int checks = 0, fails = 0;
   string tag = "R10";

   always #(CLK_PERIOD/2) clk = ~clk;

   nco_dual_bank u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .fbank_pin(fbank_pin), .pbank_pin(pbank_pin), .clear(clear), .sleep_pin(sleep_pin),
      .sample_o(sample_o), .square_o(square_o)
   );

   // Cycle model built from the requirements
   logic [27:0] m_ftw [2];
   logic [11:0] m_poff [2];
   logic [5:0]  m_ctrl;
   logic [27:0] m_acc;
   logic [11:0] m_ps;
   int          m_kind;    // 0 midscale, 1 zero, 2 triangle, 3 sine
   logic [9:0]  m_tri;
   logic [9:0]  m_addr;
   logic        m_sq;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ftw[0] = '0; m_ftw[1] = '0; m_poff[0] = '0; m_poff[1] = '0;
         m_ctrl = '0; m_acc = '0; m_ps = '0; m_kind = 0; m_sq = 1'b0;
         m_tri = '0; m_addr = '0;
      end else begin
         logic fb, pb;
         fb = m_ctrl[2] ? m_ctrl[0] : fbank_pin;
         pb = m_ctrl[2] ? m_ctrl[1] : pbank_pin;
         if (clear) begin
            m_acc = '0; m_ps = '0; m_kind = 0; m_sq = 1'b0;
         end else begin
            if (sleep_pin || m_ctrl[4]) m_kind = 1;
            else if (m_ctrl[3])         m_kind = 2;
            else                        m_kind = 3;
            m_tri  = m_ps[11] ? ~m_ps[10:1] : m_ps[10:1];
            m_addr = m_ps[11:2];
            m_sq   = m_ctrl[5] & m_ps[11];
            m_ps   = m_acc[27:16] + m_poff[pb];
            m_acc  = m_acc + m_ftw[fb];
         end
         if (wr_en) begin
            case (wr_addr)
               3'd0: m_ftw[0]  = wr_data;
               3'd1: m_ftw[1]  = wr_data;
               3'd2: m_poff[0] = wr_data[11:0];
               3'd3: m_poff[1] = wr_data[11:0];
               3'd4: m_ctrl    = wr_data[5:0];
               default: ;
            endcase
         end
      end
   end

   task automatic check_now();
      real e, s;
      int  h;
      checks++;
      case (m_kind)
         0: if (sample_o !== 10'd512) begin
               fails++; $display("FAIL %s/R6 midscale: sample=%0d expected=512", tag, sample_o);
            end
         1: if (sample_o !== 10'd0) begin
               fails++; $display("FAIL %s/R7 sleep: sample=%0d expected=0", tag, sample_o);
            end
         2: if (sample_o !== m_tri) begin
               fails++; $display("FAIL %s/R5 triangle: sample=%0d expected=%0d", tag, sample_o, m_tri);
            end
         default: begin
            h = int'(m_addr[8:0]);
            s = $sin(3.14159265358979 * (2.0 * h + 1.0) / 1024.0);
            e = m_addr[9] ? (511.0 - 511.0 * s) : (512.0 + 511.0 * s);
            if ((real'(sample_o) - e > 2.0) || (e - real'(sample_o) > 2.0)) begin
               fails++; $display("FAIL %s/R4 sine: sample=%0d expected=%0.2f", tag, sample_o, e);
            end
         end
      endcase
      checks++;
      if (square_o !== m_sq) begin
         fails++; $display("FAIL %s/R8 square: square=%0b expected=%0b", tag, square_o, m_sq);
      end
   endtask

   task automatic step(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check_now();
      end
   endtask

   task automatic wr(logic [2:0] a, logic [27:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step(1);
      wr_en = 1'b0;
   endtask

   initial begin
      fork
         begin
            // R10: reset state
            tag = "R10";
            repeat (3) @(negedge clk);
            checks++;
            if (sample_o !== 10'd512 || square_o !== 1'b0) begin
               fails++; $display("FAIL R10 reset: sample=%0d square=%0b expected=512/0", sample_o, square_o);
            end
            rst_n = 1'b1;
            step(2);

            // R9 + R5 + R1: triangle sweep over every phase value, bit-selected banks
            tag = "R9";
            wr(3'd0, 28'h0010000);
            wr(3'd4, 28'h000000C);   // triangle, select by bits
            step(3);
            tag = "R5";
            step(4200);

            // R4 + R8: sine sweep with square enabled
            tag = "R4";
            wr(3'd4, 28'h0000024);
            step(4200);

            // R2 + R3: banks switched by control bits
            tag = "R2";
            wr(3'd1, 28'h0018123);
            wr(3'd3, 28'h0000C00);
            wr(3'd2, 28'h0000155);
            wr(3'd5, 28'hFFFFFFF);   // ignored address
            wr(3'd4, 28'h0000025);
            step(300);
            tag = "R3";
            wr(3'd4, 28'h0000026);
            step(300);
            wr(3'd4, 28'h000002F);
            step(300);

            // R2 + R3: banks follow the pins, changed each cycle
            tag = "R2_pins";
            wr(3'd4, 28'h0000028);
            for (int i = 0; i < 3000; i++) begin
               fbank_pin = i[2] ^ i[0];
               pbank_pin = i[1] ^ i[4];
               step(1);
            end
            tag = "R3_pins";
            wr(3'd4, 28'h0000020);
            for (int i = 0; i < 3000; i++) begin
               fbank_pin = i[3];
               pbank_pin = i[0] ^ i[5];
               step(1);
            end

            // R7: sleep by pin and by bit
            tag = "R7";
            for (int i = 0; i < 400; i++) begin
               sleep_pin = i[3] & i[1];
               step(1);
            end
            sleep_pin = 1'b0;
            wr(3'd4, 28'h0000030);
            step(50);
            wr(3'd4, 28'h0000020);
            step(50);

            // R6: clear with writes during it, clear beats sleep
            tag = "R6";
            clear = 1'b1; sleep_pin = 1'b1;
            step(3);
            sleep_pin = 1'b0;
            wr(3'd0, 28'h00A5000);
            step(3);
            clear = 1'b0;
            step(500);
            for (int i = 0; i < 600; i++) begin
               clear = (i % 97) < 2;
               fbank_pin = i[1];
               step(1);
            end
            clear = 1'b0;

            // R1: tuning words that wrap the accumulator
            tag = "R1";
            wr(3'd0, 28'hFFFFFFF);
            wr(3'd1, 28'h8000001);
            wr(3'd4, 28'h0000028);
            for (int i = 0; i < 2000; i++) begin
               fbank_pin = i[2];
               step(1);
            end
            wr(3'd4, 28'h0000020);
            step(1000);
         end
         begin
            repeat (WATCHDOG) @(posedge clk);
            checks++; fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule